// File: doc/BRIEF.md
# Prioritized interrupt acknowledge unit

This block is the processor-facing side of an interrupt controller for one CPU. Every cycle it looks at up to 96 interrupt sources, each with a pending bit, an enable bit and an 8-bit priority, and finds the most urgent one that is both pending and enabled. It compares that choice with a priority mask and with the priority of the interrupt now being serviced, and from the result it drives a single request line to the processor.

Software works through a small register port. It switches the interface on, sets the mask, reads an acknowledge register to claim an interrupt, and writes the ID of a finished interrupt to end it. An acknowledged interrupt pre-empts the one being serviced. Each claimed interrupt stores the ID of the interrupt it pre-empted, so the interrupts in service form a linked stack. Ending the interrupt on top of the stack returns to its predecessor. Ending an interrupt further down removes it from the chain with a short walk, during which the register port is not ready.

Source selection is a two-stage registered comparator tree, so a change on the source inputs reaches the request line three clock edges later. The block tells the source logic which pending bit to clear by a one-cycle clear pulse carrying the ID.

Top module: `irq_ack_unit`

## Requirements
- R1: ID 1023 means "none". A read of the highest-pending register (offset 0x18) returns 1023 when no source is both pending and enabled, and the running ID is 1023 when nothing is in service.
- R2: A smaller priority value is more urgent. Among sources of equal priority, the lowest source number is chosen, also across comparator groups.
- R3: While the global enable input or the interface enable (offset 0x00, bit 0) is low, the highest-pending register reads 1023 and the request line stays low.
- R4: A best priority numerically above the mask (offset 0x04, bits 7:0) is not reported and leaves the request line low. A best priority equal to the mask is reported. The request line rises only when the best priority is numerically below the running priority.
- R5: The running priority (offset 0x14) reads 0x100 when nothing is in service. After an acknowledge it reads the priority of the claimed source.
- R6: A read of offset 0x0C returns 1023 and changes nothing when no source is reported or the reported priority is not below the running priority. Otherwise it returns the source ID, makes that source the running one, links the previous running ID to it, lowers the request line, and pulses the clear output with that ID in the same cycle that read data is valid.
- R7: Writing to offset 0x10 (ID in bits 9:0) the ID of the running interrupt makes its linked predecessor the running interrupt, with that predecessor's priority, or 1023 and 0x100 when there is none.
- R8: Writing an ID that is in service but not on top removes it from the chain, and the running ID and priority stay as they were. The write is ignored when nothing is in service.
- R9: Reset leaves the mask at 0xF0, the interface disabled, the running ID at 1023, the running priority at 0x100, and the request line low.
- R10: From the cycle after an end-of-interrupt write until its chain update finishes, the ready output is low. Reads and writes presented while ready is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global enable from the distributor side |
| irq_pending | input | NUM_IRQ | Pending bit per source |
| irq_enable | input | NUM_IRQ | Enable bit per source |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per source, source n in bits n*PRIO_W upward |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| reg_ready | output | 1 | Register port accepts an access this cycle |
| cpu_irq | output | 1 | Interrupt request to the processor |
| pend_clr_vld | output | 1 | One-cycle pulse: clear the pending bit named by pend_clr_id |
| pend_clr_id | output | ID_W | Source whose pending bit is to be cleared |

## Verification
The hardest case to reach is ending an interrupt from the middle of the pre-emption chain. This needs three nested acknowledges with strictly falling priority values, and a source of equal priority left pending so that it stays reported but cannot claim. The bench builds that chain, ends the middle entry, and then ends the top entry, so the running priority can only be correct if the splice took place. While the walk holds the port not ready, the bench drives a mask write and later reads the mask back unchanged.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_EOI   = 8'h10;
  localparam logic [7:0] OFS_RPRIO = 8'h14;
  localparam logic [7:0] OFS_HPID  = 8'h18;

  typedef enum logic [1:0] {EOI_IDLE, EOI_POP, EOI_WALK, EOI_FETCH} eoi_state_e;
endpackage

// File: rtl/irqa_group_sel.sv
// First tree stage: best valid entry of one group, registered.
module irqa_group_sel #(
  parameter int GROUP  = 16,
  parameter int PRIO_W = 8,
  localparam int GIW   = $clog2(GROUP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GROUP-1:0]          vld,
  input  logic [GROUP*PRIO_W-1:0]   prio,
  output logic                      o_vld,
  output logic [PRIO_W-1:0]         o_prio,
  output logic [GIW-1:0]            o_idx
);
  logic              bv;
  logic [PRIO_W-1:0] bp;
  logic [GIW-1:0]    bi;

  always_comb begin
    bv = 1'b0;
    bp = '1;
    bi = '0;
    for (int i = 0; i < GROUP; i++) begin
      // strict compare keeps the lowest index on a tie
      if (vld[i] && (!bv || prio[i*PRIO_W +: PRIO_W] < bp)) begin
        bv = 1'b1;
        bp = prio[i*PRIO_W +: PRIO_W];
        bi = GIW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_prio <= '1;
      o_idx  <= '0;
    end else begin
      o_vld  <= bv;
      o_prio <= bp;
      o_idx  <= bi;
    end
  end
endmodule

// File: rtl/irqa_final_sel.sv
// Second tree stage: best of the group winners, registered.
module irqa_final_sel
  import irqa_pkg::*;
#(
  parameter int NG     = 6,
  parameter int PRIO_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NG-1:0]          vld,
  input  logic [NG*PRIO_W-1:0]   prio,
  input  logic [NG*ID_W-1:0]     id,
  output logic                   best_vld,
  output logic [PRIO_W-1:0]      best_prio,
  output logic [ID_W-1:0]        best_id
);
  logic              bv;
  logic [PRIO_W-1:0] bp;
  logic [ID_W-1:0]   bi;

  always_comb begin
    bv = 1'b0;
    bp = '1;
    bi = NO_IRQ;
    for (int g = 0; g < NG; g++) begin
      if (vld[g] && (!bv || prio[g*PRIO_W +: PRIO_W] < bp)) begin
        bv = 1'b1;
        bp = prio[g*PRIO_W +: PRIO_W];
        bi = id[g*ID_W +: ID_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_vld  <= 1'b0;
      best_prio <= '1;
      best_id   <= NO_IRQ;
    end else begin
      best_vld  <= bv;
      best_prio <= bp;
      best_id   <= bi;
    end
  end
endmodule

// File: rtl/irqa_link_ram.sv
// Per-source predecessor link, one write port, registered read.
module irqa_link_ram #(
  parameter int DEPTH = 96,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irqa_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int GROUP   = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       dist_en,
  input  logic [NUM_IRQ-1:0]         irq_pending,
  input  logic [NUM_IRQ-1:0]         irq_enable,
  input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic                       reg_rd,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       reg_rvalid,
  output logic                       reg_ready,
  output logic                       cpu_irq,
  output logic                       pend_clr_vld,
  output logic [ID_W-1:0]            pend_clr_id
);
  localparam int NG    = (NUM_IRQ + GROUP - 1) / GROUP;
  localparam int PADN  = NG * GROUP;
  localparam int GIW   = $clog2(GROUP);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_P = (PRIO_W+1)'(1) << PRIO_W;

  // ---------------- selection tree ----------------
  logic [PADN-1:0]        cand;
  logic [PADN*PRIO_W-1:0] prio_pad;
  logic [NG-1:0]          gv;
  logic [NG*PRIO_W-1:0]   gp;
  logic [NG*ID_W-1:0]     gid;
  logic [GIW-1:0]         gi [NG];
  logic                   best_vld;
  logic [PRIO_W-1:0]      best_prio;
  logic [ID_W-1:0]        best_id;

  assign cand     = PADN'(irq_pending & irq_enable);
  assign prio_pad = (PADN*PRIO_W)'(irq_prio);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irqa_group_sel #(.GROUP(GROUP), .PRIO_W(PRIO_W)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .vld    (cand[g*GROUP +: GROUP]),
      .prio   (prio_pad[g*GROUP*PRIO_W +: GROUP*PRIO_W]),
      .o_vld  (gv[g]),
      .o_prio (gp[g*PRIO_W +: PRIO_W]),
      .o_idx  (gi[g])
    );
    assign gid[g*ID_W +: ID_W] = ID_W'(g*GROUP + int'(gi[g]));
  end

  irqa_final_sel #(.NG(NG), .PRIO_W(PRIO_W)) u_fin (
    .clk       (clk),
    .rst       (rst),
    .vld       (gv),
    .prio      (gp),
    .id        (gid),
    .best_vld  (best_vld),
    .best_prio (best_prio),
    .best_id   (best_id)
  );

  // ---------------- interface state ----------------
  logic              cpu_en;
  logic [PRIO_W-1:0] mask;
  logic [ID_W-1:0]   run_id;
  logic [PRIO_W:0]   run_prio;
  logic [ID_W-1:0]   eoi_id;
  logic [ID_W-1:0]   tmp_id;
  eoi_state_e        state;
  logic              busy;
  logic              irq_q;

  logic              rd_go, wr_go, rep_ok, ack_fire, eoi_fire;
  logic [ID_W-1:0]   rep_id;
  logic [ID_W-1:0]   eoi_in;

  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr, ram_raddr;
  logic [ID_W-1:0]   ram_wdata, mem_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:ID_W];

  assign busy      = (state != EOI_IDLE);
  assign reg_ready = !busy;
  assign cpu_irq   = irq_q;
  assign rd_go     = reg_rd && !busy;
  assign wr_go     = reg_wr && !busy;
  assign eoi_in    = reg_wdata[ID_W-1:0];

  assign rep_ok   = dist_en && cpu_en && best_vld && (best_prio <= mask);
  assign rep_id   = rep_ok ? best_id : NO_IRQ;
  assign ack_fire = rd_go && (reg_addr == ADDR_W'(OFS_ACK)) && rep_ok &&
                    ({1'b0, best_prio} < run_prio);
  assign eoi_fire = wr_go && (reg_addr == ADDR_W'(OFS_EOI));

  function automatic logic [PRIO_W:0] prio_at(input logic [ID_W-1:0] id);
    if (id == NO_IRQ) return IDLE_P;
    return {1'b0, irq_prio[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W]};
  endfunction

  // ---------------- link memory ----------------
  assign ram_we    = ack_fire || (state == EOI_FETCH);
  assign ram_waddr = ack_fire ? best_id[IDX_W-1:0] : tmp_id[IDX_W-1:0];
  assign ram_wdata = ack_fire ? run_id : mem_q;

  always_comb begin
    case (state)
      EOI_WALK: ram_raddr = (mem_q == eoi_id) ? eoi_id[IDX_W-1:0] : mem_q[IDX_W-1:0];
      default:  ram_raddr = run_id[IDX_W-1:0];
    endcase
  end

  irqa_link_ram #(.DEPTH(NUM_IRQ), .W(ID_W)) u_link (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (mem_q)
  );

  // ---------------- registers and chain control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_en       <= 1'b0;
      mask         <= PRIO_W'(8'hF0);
      run_id       <= NO_IRQ;
      run_prio     <= IDLE_P;
      eoi_id       <= NO_IRQ;
      tmp_id       <= NO_IRQ;
      state        <= EOI_IDLE;
      irq_q        <= 1'b0;
      reg_rdata    <= '0;
      reg_rvalid   <= 1'b0;
      pend_clr_vld <= 1'b0;
      pend_clr_id  <= NO_IRQ;
    end else begin
      reg_rvalid   <= rd_go;
      pend_clr_vld <= ack_fire;
      pend_clr_id  <= ack_fire ? best_id : NO_IRQ;
      irq_q        <= rep_ok && ({1'b0, best_prio} < run_prio) && !ack_fire;

      if (rd_go) begin
        case (reg_addr)
          ADDR_W'(OFS_CTRL):  reg_rdata <= DATA_W'(cpu_en);
          ADDR_W'(OFS_MASK):  reg_rdata <= DATA_W'(mask);
          ADDR_W'(OFS_ACK):   reg_rdata <= DATA_W'(ack_fire ? best_id : NO_IRQ);
          ADDR_W'(OFS_RPRIO): reg_rdata <= DATA_W'(run_prio);
          ADDR_W'(OFS_HPID):  reg_rdata <= DATA_W'(rep_id);
          default:            reg_rdata <= '0;
        endcase
      end

      if (wr_go && reg_addr == ADDR_W'(OFS_CTRL)) cpu_en <= reg_wdata[0];
      if (wr_go && reg_addr == ADDR_W'(OFS_MASK)) mask   <= reg_wdata[PRIO_W-1:0];

      if (ack_fire) begin
        run_id   <= best_id;
        run_prio <= {1'b0, best_prio};
      end

      case (state)
        EOI_IDLE: begin
          if (eoi_fire && run_id != NO_IRQ) begin
            eoi_id <= eoi_in;
            tmp_id <= run_id;
            state  <= (eoi_in == run_id) ? EOI_POP : EOI_WALK;
          end
        end
        EOI_POP: begin
          run_id   <= mem_q;
          run_prio <= prio_at(mem_q);
          state    <= EOI_IDLE;
        end
        EOI_WALK: begin
          if (mem_q == NO_IRQ)      state  <= EOI_IDLE;
          else if (mem_q == eoi_id) state  <= EOI_FETCH;
          else                      tmp_id <= mem_q;
        end
        default: state <= EOI_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker
  import irqa_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dist_en,
  input logic              cpu_en,
  input logic              cpu_irq,
  input logic              busy,
  input logic              ack_fire,
  input logic              eoi_fire,
  input logic              pend_clr_vld,
  input logic [ID_W-1:0]   run_id,
  input logic [PRIO_W:0]   run_prio
);
  // R3
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!dist_en || !cpu_en) |=> !cpu_irq);

  // R5
  idle_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (run_id == NO_IRQ) |-> (run_prio == ((PRIO_W+1)'(1) << PRIO_W)));

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pend_clr_vld |-> !cpu_irq);

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ack_fire) && !$past(busy)) |-> $stable(run_id));

  // R8
  eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_fire && run_id == NO_IRQ) |=> !busy);
endmodule

bind irq_ack_unit irqa_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dist_en      (dist_en),
  .cpu_en       (cpu_en),
  .cpu_irq      (cpu_irq),
  .busy         (busy),
  .ack_fire     (ack_fire),
  .eoi_fire     (eoi_fire),
  .pend_clr_vld (pend_clr_vld),
  .run_id       (run_id),
  .run_prio     (run_prio)
);

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;
  localparam int N  = 96;
  localparam int PW = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_ACK = 8'h0C,
                         A_EOI = 8'h10, A_RPRIO = 8'h14, A_HPID = 8'h18;
  localparam logic [31:0] NONE = 32'd1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dist_en = 1'b0;
  logic [N-1:0] pend = '0;
  logic [N-1:0] en = '0;
  logic [N*PW-1:0] pr = '1;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, reg_ready, cpu_irq, pend_clr_vld;
  logic [9:0] pend_clr_id;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  irq_ack_unit u_dut (
    .clk (clk), .rst (rst), .dist_en (dist_en),
    .irq_pending (pend), .irq_enable (en), .irq_prio (pr),
    .reg_rd (reg_rd), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reg_rvalid (reg_rvalid),
    .reg_ready (reg_ready), .cpu_irq (cpu_irq),
    .pend_clr_vld (pend_clr_vld), .pend_clr_id (pend_clr_id)
  );

  typedef struct packed {
    logic       d;
    logic       c;
    logic [7:0] m;
    logic [6:0] a;
    logic [7:0] pa;
    logic [6:0] b;
    logic [7:0] pb;
    logic       eb;
    logic [9:0] ex;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 8'hF0, 7'd5,   8'h40, 7'd70,  8'h20, 1'b1, 10'd70},   // R2
    '{1'b1, 1'b1, 8'hF0, 7'd9,   8'h30, 7'd3,   8'h30, 1'b1, 10'd3},    // R2 tie
    '{1'b1, 1'b1, 8'hF0, 7'd48,  8'h30, 7'd47,  8'h30, 1'b1, 10'd47},   // R2 tie across groups
    '{1'b1, 1'b1, 8'h20, 7'd10,  8'h30, 7'd11,  8'h21, 1'b1, 10'd1023}, // R4 above mask
    '{1'b1, 1'b1, 8'h21, 7'd10,  8'h30, 7'd11,  8'h21, 1'b1, 10'd11},   // R4 equal mask
    '{1'b0, 1'b1, 8'hF0, 7'd10,  8'h30, 7'd11,  8'h21, 1'b1, 10'd1023}, // R3
    '{1'b1, 1'b0, 8'hF0, 7'd10,  8'h30, 7'd11,  8'h21, 1'b1, 10'd1023}, // R3
    '{1'b1, 1'b1, 8'hF0, 7'd95,  8'h00, 7'd0,   8'h01, 1'b1, 10'd95},   // R2
    '{1'b1, 1'b1, 8'hF0, 7'd127, 8'h00, 7'd127, 8'h00, 1'b1, 10'd1023}, // R1
    '{1'b1, 1'b1, 8'hF0, 7'd12,  8'h50, 7'd13,  8'h10, 1'b0, 10'd12},   // R1 disabled
    '{1'b1, 1'b1, 8'hF0, 7'd12,  8'hF1, 7'd127, 8'h00, 1'b1, 10'd1023}  // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    while (!reg_ready) @(negedge clk);
    reg_rd = 1'b1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    while (!reg_ready) @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_ready();
    while (!reg_ready) @(negedge clk);
  endtask

  task automatic clear_src();
    pend = '0;
    en = '0;
    pr = '1;
  endtask

  task automatic set_src(input int n, input logic [7:0] p, input logic e);
    pend[n] = 1'b1;
    en[n] = e;
    pr[n*PW +: PW] = p;
  endtask

  task automatic ack_expect(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_ACK, d);
    chk({tag, " ack id"}, d, exp);
    chk({tag, " clear pulse"}, {31'd0, pend_clr_vld}, {31'd0, exp != NONE});
    if (exp != NONE) begin
      chk({tag, " clear id"}, {22'd0, pend_clr_id}, exp);
      pend[exp[6:0]] = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R9 reset state
    chk("R9 irq low", {31'd0, cpu_irq}, 32'd0);
    rd(A_MASK, d);   chk("R9 mask", d, 32'hF0);
    rd(A_CTRL, d);   chk("R9 ctrl", d, 32'd0);
    rd(A_RPRIO, d);  chk("R9 run prio", d, 32'h100);
    rd(A_HPID, d);   chk("R9/R1 hp id", d, NONE);

    // table walk, nothing in service
    for (int i = 0; i < NV; i++) begin
      clear_src();
      dist_en = TBL[i].d;
      wr(A_CTRL, {31'd0, TBL[i].c});
      wr(A_MASK, {24'd0, TBL[i].m});
      if (TBL[i].a < 7'd96) set_src(int'(TBL[i].a), TBL[i].pa, 1'b1);
      if (TBL[i].b < 7'd96) set_src(int'(TBL[i].b), TBL[i].pb, TBL[i].eb);
      settle();
      rd(A_HPID, d);
      chk($sformatf("R1/R2/R3/R4 table %0d hp", i), d, {22'd0, TBL[i].ex});
      chk($sformatf("R3/R4 table %0d irq", i), {31'd0, cpu_irq},
          {31'd0, TBL[i].ex != 10'd1023});
    end

    // nesting
    clear_src();
    dist_en = 1'b1;
    wr(A_CTRL, 32'd1);
    wr(A_MASK, 32'hF0);
    set_src(20, 8'h80, 1'b1);
    settle();
    chk("R4 irq raised", {31'd0, cpu_irq}, 32'd1);
    ack_expect("R6 first", 32'd20);
    chk("R6 irq dropped", {31'd0, cpu_irq}, 32'd0);
    settle();
    rd(A_RPRIO, d);  chk("R5 run prio after ack", d, 32'h80);

    set_src(30, 8'h80, 1'b1);
    settle();
    chk("R4 equal prio no irq", {31'd0, cpu_irq}, 32'd0);
    ack_expect("R6 equal prio", NONE);

    set_src(31, 8'h40, 1'b1);
    settle();
    chk("R4 preempt irq", {31'd0, cpu_irq}, 32'd1);
    ack_expect("R6 second", 32'd31);
    settle();
    set_src(32, 8'h10, 1'b1);
    settle();
    ack_expect("R6 third", 32'd32);
    settle();
    rd(A_RPRIO, d);  chk("R5 run prio nested", d, 32'h10);
    rd(A_HPID, d);   chk("R4 hp reported without irq", d, 32'd30);

    // R8 splice of middle entry, R10 busy
    wr(A_EOI, 32'd31);
    chk("R10 not ready during walk", {31'd0, reg_ready}, 32'd0);
    reg_wr = 1'b1;
    reg_addr = A_MASK;
    reg_wdata = 32'd0;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_ready();
    rd(A_MASK, d);   chk("R10 write while busy ignored", d, 32'hF0);
    rd(A_RPRIO, d);  chk("R8 run prio kept", d, 32'h10);

    // R7 pop goes to 20 because 31 was removed
    wr(A_EOI, 32'd32);
    wait_ready();
    settle();
    rd(A_RPRIO, d);  chk("R7 pop to spliced predecessor", d, 32'h80);
    chk("R4 no irq at equal", {31'd0, cpu_irq}, 32'd0);

    wr(A_EOI, 32'd20);
    wait_ready();
    settle();
    rd(A_RPRIO, d);  chk("R7 pop to none", d, 32'h100);
    chk("R4 irq after return", {31'd0, cpu_irq}, 32'd1);
    ack_expect("R6 after return", 32'd30);
    wr(A_EOI, 32'd30);
    wait_ready();

    // R8 ignored when nothing runs
    wr(A_EOI, 32'd5);
    chk("R8 idle eoi no busy", {31'd0, reg_ready}, 32'd1);
    rd(A_RPRIO, d);  chk("R8 idle eoi prio", d, 32'h100);

    // R9 reset mid-run
    set_src(40, 8'h20, 1'b1);
    settle();
    ack_expect("R6 before reset", 32'd40);
    do_reset();
    rd(A_RPRIO, d);  chk("R9 run prio after reset", d, 32'h100);
    rd(A_MASK, d);   chk("R9 mask after reset", d, 32'hF0);
    rd(A_HPID, d);   chk("R9 hp after reset", d, NONE);
    chk("R9 irq after reset", {31'd0, cpu_irq}, 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule